// File: doc/BRIEF.md
# Product-Form Sparse Ternary Convolution Unit

This block multiplies a dense polynomial `h` by a blinding polynomial built as `r = a*b + c`, in the ring of integers modulo 2^11 and modulo `X^N - 1`. It then adds a dense message polynomial `m`. Each of the three factors `a`, `b` and `c` is sparse ternary. It is never stored densely: each factor is described by one list of the positions of its +1 coefficients and one list of the positions of its -1 coefficients, and every position is an 11-bit index.

The computation runs in two chained phases. In the first phase, `t = b*h` is built into a scratch memory. In the second phase, for every output coefficient, the unit starts from `m_k`, adds `a*t` and `c*h`, and writes the sum back over the message slot. Each step handles one nonzero term. A +1 at position `i` adds the source coefficient `(k - i) mod N` to output `k`, and a -1 at that position subtracts it. The host loads `h`, `m` and the six lists, pulses `start`, waits for `done`, and then reads the result four coefficients per read.

Top module: `pf_sparse_conv`

## Requirements
- R1: After a run, coefficient k of the result equals (m_k + sum over j of r_j * h_((k-j) mod N)) mod 2048, where r = a*b + c is the cyclic product of the dense expansions of the lists.
- R2: Index words are accepted on `idx_valid && idx_ready` into six lists of D entries, in the fixed order a+, a-, b+, b-, c+, c-. `idx_ready` drops once 6·D words have been taken, and an accepted `start` re-arms loading from the first slot.
- R3: The first phase writes all N scratch entries before the second phase reads any of them, and `done` rises exactly 6·D·N clock edges after the edge that accepts `start`.
- R4: `busy` is high from the edge that accepts `start` until `done`. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R5: `start` asserted while `busy` is high has no effect on the latency or on the result.
- R6: Writes to `h` or `m` while `busy` is high are ignored.
- R7: `rd_data` returns, one clock edge after `rd_grp` is set, the coefficients 4·g+l in bits [11·l +: 11] for lanes l = 0..3. Lanes whose index is at or above N read as 0.
- R8: Positions 0 and N-1 wrap around the ring correctly.
- R9: Message coefficients use 11-bit two's complement, so -1 is written as 2047. Negative sums wrap modulo 2048.
- R10: After reset, `busy` = 0, `done` = 0, `idx_ready` = 1 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr_en | input | 1 | Write one coefficient of h |
| h_wr_addr | input | AW | Coefficient index for h |
| h_wr_data | input | QW | Coefficient value for h |
| m_wr_en | input | 1 | Write one coefficient of m |
| m_wr_addr | input | AW | Coefficient index for m |
| m_wr_data | input | QW | Coefficient value for m (two's complement) |
| idx_valid | input | 1 | Index word offered |
| idx_data | input | IW | Position of a nonzero coefficient |
| idx_ready | output | 1 | Index word can be taken |
| start | input | 1 | Begin a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_grp | input | GW | Result group to read |
| rd_data | output | 4·QW | Four result coefficients of the group |

## Verification
The bench builds the unit with N = 23 and D = 5. With these values a run lasts 690 cycles, so many full runs fit in the time budget. Because 23 is not a multiple of four, the last read group contains padded lanes. The small ring also lets random position lists land on both ends of the index range and exercise the wrap-around often, alongside directed lists that place positions at 0 and N-1.

// File: rtl/pfc_pkg.sv
// Shared types for the product-form sparse convolution unit.
// Assumes nothing beyond IEEE 1800-2017.
package pfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL1 = 2'd1,   // t = b*h into scratch
        ST_MUL2 = 2'd2,   // e = m + a*t + c*h
        ST_DONE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pfc_coef_ram.sv
// Coefficient memory: N words of W bits, one synchronous write port and
// NRD combinational read ports. Reads at or above N return zero.
// Assumes the writer keeps wa below N.
module pfc_coef_ram #(
    parameter int N   = 1171,
    parameter int W   = 11,
    parameter int AW  = 11,
    parameter int NRD = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra [NRD],
    output logic [W-1:0]  rq [NRD]
);
    logic [W-1:0] mem [N];

    // Store one coefficient per write.
    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    // Read ports, zero outside the ring.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rq[p] = (32'(ra[p]) < N) ? mem[ra[p]] : '0;
    end

    a_r6_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(wa) < N));
endmodule

// File: rtl/pfc_idx_store.sv
// Holds the six position lists (a+, a-, b+, b-, c+, c-; D entries each)
// loaded in that order through a valid/ready port. Loading stops after
// 6*D words and restarts from slot 0 when a run is accepted.
module pfc_idx_store #(
    parameter int N   = 1171,
    parameter int D   = 5,
    parameter int IW  = 11,
    localparam int NSL = 6 * D,
    localparam int SLW = $clog2(NSL),
    localparam int CW  = $clog2(NSL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           busy,
    input  logic           clr,
    input  logic           in_valid,
    input  logic [IW-1:0]  in_data,
    output logic           in_ready,
    input  logic [SLW-1:0] rd_slot,
    output logic [IW-1:0]  rd_idx
);
    logic [IW-1:0] lst [NSL];
    logic [CW-1:0] cnt;

    assign in_ready = !busy && (cnt < CW'(NSL));
    assign rd_idx   = lst[rd_slot];

    // Fill counter: advance on accept, clear on run start.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (clr)                  cnt <= '0;
        else if (in_valid && in_ready) cnt <= cnt + 1'b1;
    end

    // List storage written in arrival order.
    always_ff @(posedge clk) begin
        if (in_valid && in_ready) lst[cnt[SLW-1:0]] <= in_data;
    end

    a_r2_index_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (32'(in_data) < N));
endmodule

// File: rtl/pfc_seq.sv
// Run controller and accumulator. One nonzero term per cycle: phase 1
// walks b's 2D positions for each k and writes t; phase 2 walks a's 2D
// positions over t then c's 2D positions over h, seeded with m_k, and
// writes e_k over m_k. Assumes memories read combinationally.
module pfc_seq
    import pfc_pkg::*;
#(
    parameter int N  = 1171,
    parameter int D  = 5,
    parameter int IW = 11,
    parameter int AW = 11,
    parameter int QW = 11,
    localparam int SLW = $clog2(6 * D),
    localparam int JW  = $clog2(4 * D)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic           run_acc,
    output logic [SLW-1:0] slot,
    input  logic [IW-1:0]  idx,
    output logic [AW-1:0]  src_addr,
    input  logic [QW-1:0]  h_q,
    input  logic [QW-1:0]  t_q,
    output logic           t_we,
    output logic [AW-1:0]  k_addr,
    output logic [QW-1:0]  wr_val,
    input  logic [QW-1:0]  me_q,
    output logic           me_we
);
    seq_state_t    state;
    logic [AW-1:0] k;
    logic [JW-1:0] j;
    logic [QW-1:0] acc;
    logic          t_full;

    logic          in1, in2, last_j, from_t, neg;
    logic [JW-1:0] jm;
    logic [IW:0]   kk, ii, diff;
    logic [QW-1:0] term, base;

    assign in1     = (state == ST_MUL1);
    assign in2     = (state == ST_MUL2);
    assign busy    = in1 || in2;
    assign done    = (state == ST_DONE);
    assign run_acc = start && (state == ST_IDLE);
    assign k_addr  = k;

    // Term decode: list slot, sign and source memory for step j.
    always_comb begin
        last_j = in1 ? (j == JW'(2 * D - 1)) : (j == JW'(4 * D - 1));
        from_t = in2 && (j < JW'(2 * D));
        slot   = from_t ? SLW'(j) : SLW'(j) + SLW'(2 * D);
        jm     = (j >= JW'(2 * D)) ? JW'(j - JW'(2 * D)) : j;
        neg    = (jm >= JW'(D));
    end

    // Cyclic source address (k - idx) mod N.
    always_comb begin
        kk       = (IW + 1)'(k);
        ii       = (IW + 1)'(idx);
        diff     = (kk >= ii) ? (kk - ii) : (kk + (IW + 1)'(N) - ii);
        src_addr = AW'(diff);
    end

    // Accumulate one signed term; the sum wraps modulo 2^QW.
    always_comb begin
        term   = from_t ? t_q : h_q;
        base   = (j == '0) ? (in2 ? me_q : '0) : acc;
        wr_val = neg ? (base - term) : (base + term);
        t_we   = in1 && last_j;
        me_we  = in2 && last_j;
    end

    // Phase, coefficient and term counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            k      <= '0;
            j      <= '0;
            acc    <= '0;
            t_full <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_MUL1;
                    k      <= '0;
                    j      <= '0;
                    t_full <= 1'b0;
                end
                ST_MUL1, ST_MUL2: begin
                    acc <= wr_val;
                    if (last_j) begin
                        j <= '0;
                        if (k == AW'(N - 1)) begin
                            k <= '0;
                            if (in1) begin
                                state  <= ST_MUL2;
                                t_full <= 1'b1;
                            end else begin
                                state <= ST_DONE;
                            end
                        end else begin
                            k <= k + 1'b1;
                        end
                    end else begin
                        j <= j + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r3_t_complete: assert property (@(posedge clk) disable iff (!rst_n)
        in2 |-> t_full);
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r8_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(src_addr) < N));
endmodule

// File: rtl/pf_sparse_conv.sv
// Top: e = m + (a*b + c)*h mod 2^QW over Z[X]/(X^N - 1), with a, b, c
// given as position lists. Holds h, scratch t and m/e memories; m is
// overwritten by e. Host writes are blocked during a run.
module pf_sparse_conv #(
    parameter int N     = 1171,
    parameter int D     = 5,
    parameter int IW    = 11,
    parameter int QW    = 11,
    parameter int LANES = 4,
    localparam int AW   = $clog2(N),
    localparam int NGRP = (N + LANES - 1) / LANES,
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int SLW  = $clog2(6 * D)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_wr_en,
    input  logic [AW-1:0]       h_wr_addr,
    input  logic [QW-1:0]       h_wr_data,
    input  logic                m_wr_en,
    input  logic [AW-1:0]       m_wr_addr,
    input  logic [QW-1:0]       m_wr_data,
    input  logic                idx_valid,
    input  logic [IW-1:0]       idx_data,
    output logic                idx_ready,
    input  logic                start,
    output logic                busy,
    output logic                done,
    input  logic [GW-1:0]       rd_grp,
    output logic [LANES*QW-1:0] rd_data
);
    logic           run_acc, t_we, me_we_s;
    logic [SLW-1:0] slot;
    logic [IW-1:0]  idx;
    logic [AW-1:0]  src_addr, k_addr;
    logic [QW-1:0]  wr_val;
    logic [AW-1:0]  h_ra [1];
    logic [QW-1:0]  h_rq [1];
    logic [AW-1:0]  t_ra [1];
    logic [QW-1:0]  t_rq [1];
    logic [AW-1:0]  me_ra [LANES + 1];
    logic [QW-1:0]  me_rq [LANES + 1];
    logic           me_we, h_we;
    logic [AW-1:0]  me_wa;
    logic [QW-1:0]  me_wd;
    logic [LANES*QW-1:0] grp_word;

    assign h_ra[0]  = src_addr;
    assign t_ra[0]  = src_addr;
    assign me_ra[0] = k_addr;
    assign h_we     = h_wr_en && !busy;
    assign me_we    = busy ? me_we_s : m_wr_en;
    assign me_wa    = busy ? k_addr  : m_wr_addr;
    assign me_wd    = busy ? wr_val  : m_wr_data;

    pfc_idx_store #(.N(N), .D(D), .IW(IW)) u_idx (
        .clk(clk), .rst_n(rst_n), .busy(busy), .clr(run_acc),
        .in_valid(idx_valid), .in_data(idx_data), .in_ready(idx_ready),
        .rd_slot(slot), .rd_idx(idx)
    );

    pfc_seq #(.N(N), .D(D), .IW(IW), .AW(AW), .QW(QW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .run_acc(run_acc), .slot(slot), .idx(idx), .src_addr(src_addr),
        .h_q(h_rq[0]), .t_q(t_rq[0]), .t_we(t_we), .k_addr(k_addr),
        .wr_val(wr_val), .me_q(me_rq[0]), .me_we(me_we_s)
    );

    pfc_coef_ram #(.N(N), .W(QW), .AW(AW), .NRD(1)) u_h_ram (
        .clk(clk), .rst_n(rst_n), .we(h_we), .wa(h_wr_addr),
        .wd(h_wr_data), .ra(h_ra), .rq(h_rq)
    );

    pfc_coef_ram #(.N(N), .W(QW), .AW(AW), .NRD(1)) u_t_ram (
        .clk(clk), .rst_n(rst_n), .we(t_we), .wa(k_addr),
        .wd(wr_val), .ra(t_ra), .rq(t_rq)
    );

    pfc_coef_ram #(.N(N), .W(QW), .AW(AW), .NRD(LANES + 1)) u_me_ram (
        .clk(clk), .rst_n(rst_n), .we(me_we), .wa(me_wa),
        .wd(me_wd), .ra(me_ra), .rq(me_rq)
    );

    // Group read lanes; indices past the ring read as zero.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [AW+GW:0] full;
        assign full = (AW + GW + 1)'(rd_grp) * (AW + GW + 1)'(LANES) + (AW + GW + 1)'(l);
        assign me_ra[l + 1] = AW'(full);
        assign grp_word[l*QW +: QW] = (32'(full) < N) ? me_rq[l + 1] : '0;
    end

    // Registered result read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= grp_word;
    end
endmodule

// File: tb/pf_sparse_conv_tb.sv
module pf_sparse_conv_tb;
    localparam int N = 23, D = 5, IW = 11, QW = 11, LANES = 4;
    localparam int AW = $clog2(N);
    localparam int NGRP = (N + LANES - 1) / LANES;
    localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int NSL = 6 * D;
    localparam int LAT = 6 * D * N;

    logic clk = 0, rst_n = 0;
    logic h_wr_en = 0, m_wr_en = 0, idx_valid = 0, start = 0;
    logic [AW-1:0] h_wr_addr = '0, m_wr_addr = '0;
    logic [QW-1:0] h_wr_data = '0, m_wr_data = '0;
    logic [IW-1:0] idx_data = '0;
    logic [GW-1:0] rd_grp = '0;
    logic idx_ready, busy, done;
    logic [LANES*QW-1:0] rd_data;

    int n_chk = 0, n_bad = 0;
    int hh [N], mm [N], ee [N];
    int lst [NSL];

    pf_sparse_conv #(.N(N), .D(D), .IW(IW), .QW(QW), .LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_wr_addr(h_wr_addr),
        .h_wr_data(h_wr_data), .m_wr_en(m_wr_en), .m_wr_addr(m_wr_addr),
        .m_wr_data(m_wr_data), .idx_valid(idx_valid), .idx_data(idx_data),
        .idx_ready(idx_ready), .start(start), .busy(busy), .done(done),
        .rd_grp(rd_grp), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int md(input int x);
        return ((x % N) + N) % N;
    endfunction

    // Reference: expand lists, r = a*b + c, e = m + r*h mod 2048.
    task automatic compute_ref();
        int fa [N], fb [N], fc [N], rr [N];
        for (int i = 0; i < N; i++) begin fa[i] = 0; fb[i] = 0; fc[i] = 0; end
        for (int s = 0; s < NSL; s++) begin
            int sg = ((s / D) % 2 == 0) ? 1 : -1;
            case (s / (2 * D))
                0: fa[lst[s]] += sg;
                1: fb[lst[s]] += sg;
                default: fc[lst[s]] += sg;
            endcase
        end
        for (int k = 0; k < N; k++) begin
            rr[k] = fc[k];
            for (int i = 0; i < N; i++) rr[k] += fa[i] * fb[md(k - i)];
        end
        for (int k = 0; k < N; k++) begin
            int acc = mm[k];
            for (int i = 0; i < N; i++) acc += rr[i] * hh[md(k - i)];
            ee[k] = ((acc % 2048) + 2048) % 2048;
        end
    endtask

    // Random lists: 2D distinct positions per factor.
    task automatic rand_lists();
        for (int f = 0; f < 3; f++) begin
            bit used [N];
            for (int i = 0; i < N; i++) used[i] = 0;
            for (int e = 0; e < 2 * D; e++) begin
                int p;
                do p = $urandom_range(N - 1); while (used[p]);
                used[p] = 1;
                lst[f * 2 * D + e] = p;
            end
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            h_wr_en = 1; h_wr_addr = AW'(i); h_wr_data = QW'(hh[i]);
            m_wr_en = 1; m_wr_addr = AW'(i); m_wr_data = QW'(mm[i]);
        end
        @(negedge clk);
        h_wr_en = 0; m_wr_en = 0;
        for (int s = 0; s < NSL; s++) begin
            if (!idx_ready) chk("R2 ready during load", 0, 1);
            idx_valid = 1; idx_data = IW'(lst[s]);
            @(negedge clk);
        end
        idx_valid = 0;
        chk("R2 ready low when full", int'(idx_ready), 0);
        idx_valid = 1; idx_data = IW'(0);   // extra word must be dropped
        @(negedge clk);
        idx_valid = 0;
    endtask

    task automatic run_check(input string tag, input bit disturb);
        int lat = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R4 busy after start", int'(busy), 1);
        while (!done && lat < LAT + 100) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 50) begin
                start = 1; m_wr_en = 1; m_wr_addr = '0; m_wr_data = QW'(7);
                h_wr_en = 1; h_wr_addr = '0; h_wr_data = QW'(9);
            end else if (disturb && lat == 51) begin
                start = 0; m_wr_en = 0; h_wr_en = 0;
            end
        end
        chk("R3 latency", lat, LAT);
        chk("R4 busy low at done", int'(busy), 0);
        @(negedge clk);
        chk("R4 done one cycle", int'(done), 0);
        chk("R2 ready after run", int'(idx_ready), 1);
        for (int g = 0; g < NGRP; g++) begin
            rd_grp = GW'(g);
            @(negedge clk);
            for (int l = 0; l < LANES; l++) begin
                int ci = g * LANES + l;
                int exp = (ci < N) ? ee[ci] : 0;
                chk($sformatf("R1 R7 %s coef %0d", tag, ci),
                    int'(rd_data[l*QW +: QW]), exp);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R10 busy", int'(busy), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 idx_ready", int'(idx_ready), 1);
        chk("R10 rd_data", int'(rd_data), 0);
        rst_n = 1;

        // Unit impulse h: result equals dense r (R1).
        for (int i = 0; i < N; i++) begin hh[i] = (i == 0); mm[i] = 0; end
        rand_lists();
        compute_ref();
        load_all();
        run_check("impulse", 0);

        // Ring ends in every list, negative messages (R8, R9).
        rand_lists();
        for (int f = 0; f < 3; f++) begin
            bit has0 = 0, hasl = 0;
            for (int e = 0; e < 2 * D; e++) begin
                has0 |= (lst[f*2*D+e] == 0); hasl |= (lst[f*2*D+e] == N - 1);
            end
            if (!has0 && !hasl) begin
                lst[f*2*D] = 0; lst[f*2*D + D] = N - 1;
            end
        end
        for (int i = 0; i < N; i++) begin
            hh[i] = $urandom_range(2047);
            mm[i] = (i % 3 == 0) ? 2047 : (i % 3);
        end
        compute_ref();
        load_all();
        run_check("R8 R9 wrap", 0);

        // Start and writes during a run are ignored (R5, R6).
        rand_lists();
        for (int i = 0; i < N; i++) begin hh[i] = $urandom_range(2047); mm[i] = 0; end
        compute_ref();
        load_all();
        run_check("R5 R6 disturb", 1);

        // All-max h, random lists.
        rand_lists();
        for (int i = 0; i < N; i++) begin hh[i] = 2047; mm[i] = 2047; end
        compute_ref();
        load_all();
        run_check("max", 0);

        for (int t = 0; t < 5; t++) begin
            rand_lists();
            for (int i = 0; i < N; i++) begin
                hh[i] = $urandom_range(2047);
                mm[i] = $urandom_range(2) == 2 ? 2047 : $urandom_range(1);
            end
            compute_ref();
            load_all();
            run_check("random", 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R4 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule